// File: doc/BRIEF.md
# Fetch Target Predictor with Return Stack

This block sits beside the fetch stage. A fetch PC arrives, and in that same cycle the block answers with a taken/not-taken guess and the PC to fetch next. No register lies between the PC and the answer. The guess comes from one of three sources, in this order of precedence:

- a small return-address stack, when the fetch stage flags the instruction as a return;
- a direct-mapped table of branch targets, when the fetch PC fully matches a stored branch;
- the sequential address, in every other case.

A later pipeline stage writes resolved branches back into the table. Call and return hints from the fetch stage push and pop the stack.

The table is indexed by the PC bits just above the two byte-offset bits. Each slot holds a valid bit, the remaining upper PC bits as a tag, and a full target address. A stored target is used only when the whole tag matches. The stack is circular: when it is full, a new push overwrites its oldest entry.

Top module: `fetch_target_pred`

## Requirements
- R1: After reset every table slot is invalid and the stack is empty. Any lookup then gives pred_taken=0, pred_hit=0, pred_from_ras=0 and pred_next_pc=fetch_pc+4.
- R2: The slot index is fetch_pc[IDX_W+1:2] and the tag is fetch_pc[PC_W-1:IDX_W+2]. A valid slot whose tag differs from the fetch PC's tag is a miss, which gives not-taken and fetch_pc+4.
- R3: On a table hit with no return hint, pred_taken=1, pred_hit=1 and pred_next_pc is the stored target, all in the cycle the PC is presented.
- R4: An update with upd_valid=1 and upd_taken=1 writes the slot selected by upd_pc with its tag and upd_target, and marks it valid, from the next cycle on.
- R5: An update with upd_taken=0 invalidates its slot only when the stored tag equals the tag of upd_pc. A not-taken update carrying a different tag leaves the stored entry usable.
- R6: When an update and a lookup address the same slot in one cycle, the lookup sees the contents from before the update.
- R7: fetch_call=1 pushes fetch_pc+4. While the stack is non-empty, fetch_ret=1 gives pred_taken=1, pred_from_ras=1 and the most recently pushed value as pred_next_pc, and pops that value at the clock edge. The stack takes precedence over a table hit on the same PC.
- R8: Once RAS_DEPTH values are held, a further push overwrites the oldest. Later returns yield the newest RAS_DEPTH values, newest first.
- R9: fetch_ret=1 with an empty stack gives a miss, never stale data: pred_taken=0, pred_from_ras=0, pred_hit=0 and pred_next_pc=fetch_pc+4. The table is not consulted.
- R10: pred_hit and pred_from_ras are never both 1, and either being 1 implies pred_taken=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | PC being fetched this cycle |
| fetch_call | input | 1 | Fetch hint: instruction is a call, push fetch_pc+4 |
| fetch_ret | input | 1 | Fetch hint: instruction is a return, predict from stack |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction of the branch |
| upd_target | input | PC_W | Resolved target of a taken branch |
| pred_taken | output | 1 | Predicted direction |
| pred_next_pc | output | PC_W | Predicted next fetch PC |
| pred_hit | output | 1 | Prediction came from the target table |
| pred_from_ras | output | 1 | Prediction came from the return stack |

## Verification
The checker assumes that fetch_call and fetch_ret are never both asserted in one cycle, since a single instruction is either a call or a return. Every bench task drives at most one of the two hints. The update-visibility properties also assume that a lookup at exactly the updated PC in the following cycle is not a return. The bench issues its table lookups with fetch_ret low, except in the precedence case, where the stack is expected to win. Update and fetch inputs change only on the falling clock edge, so each property sees stable values at the sampling edge.

// File: rtl/ftp_pkg.sv
package ftp_pkg;

   // Source that produced the current prediction
   typedef enum logic [1:0] {
      SRC_SEQ   = 2'd0,
      SRC_TABLE = 2'd1,
      SRC_STACK = 2'd2
   } pred_src_e;

   // Byte size of one instruction slot; the sequential PC adds this
   localparam int unsigned INSTR_BYTES = 4;
   localparam int unsigned OFS_W       = 2;

endpackage

// File: rtl/ftp_target_table.sv
module ftp_target_table #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned IDX_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] look_pc,
   output logic            look_hit,
   output logic [PC_W-1:0] look_target,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken,
   input  logic [PC_W-1:0] upd_target
);
   import ftp_pkg::*;

   localparam int unsigned ENTRIES = 1 << IDX_W;
   localparam int unsigned TAG_LO  = IDX_W + OFS_W;
   localparam int unsigned TAG_W   = PC_W - TAG_LO;

   generate
      if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
         $error("ftp_target_table: IDX_W must be 1..10");
      end
      if (PC_W <= TAG_LO) begin : g_bad_tag
         $error("ftp_target_table: PC_W leaves no tag bits");
      end
   endgenerate

   logic [ENTRIES-1:0] vld_q;
   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [PC_W-1:0]    tgt_q [ENTRIES];

   logic [IDX_W-1:0] look_idx, upd_idx;
   logic [TAG_W-1:0] look_tag, upd_tag;
   logic [2*OFS_W-1:0] unused_lsb;

   assign look_idx   = look_pc[TAG_LO-1:OFS_W];
   assign look_tag   = look_pc[PC_W-1:TAG_LO];
   assign upd_idx    = upd_pc[TAG_LO-1:OFS_W];
   assign upd_tag    = upd_pc[PC_W-1:TAG_LO];
   assign unused_lsb = {look_pc[OFS_W-1:0], upd_pc[OFS_W-1:0]};

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
         logic sel, wr_en, clr_en;
         assign sel    = upd_valid && (upd_idx == IDX_W'(e));
         assign wr_en  = sel && upd_taken;
         assign clr_en = sel && !upd_taken && (tag_q[e] == upd_tag);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q[e] <= 1'b0;
            end else if (wr_en) begin
               vld_q[e] <= 1'b1;
            end else if (clr_en) begin
               vld_q[e] <= 1'b0;
            end
         end

         always_ff @(posedge clk) begin
            if (wr_en) begin
               tag_q[e] <= upd_tag;
               tgt_q[e] <= upd_target;
            end
         end
      end
   endgenerate

   // Lookup reads registered state only: a same-cycle write is not visible
   assign look_hit    = vld_q[look_idx] && (tag_q[look_idx] == look_tag);
   assign look_target = tgt_q[look_idx];

endmodule

// File: rtl/ftp_return_stack.sv
module ftp_return_stack #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned DEPTH = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic [PC_W-1:0] push_val,
   input  logic            pop,
   output logic            top_valid,
   output logic [PC_W-1:0] top_val
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("ftp_return_stack: DEPTH must be a power of two >= 2");
      end
   endgenerate

   logic [PC_W-1:0]  mem_q [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q;
   logic [CNT_W-1:0] cnt_q;
   logic             full, empty;

   assign full  = (cnt_q == CNT_W'(DEPTH));
   assign empty = (cnt_q == '0);

   // Pointer wraps naturally: a push when full lands on the oldest slot
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         cnt_q    <= '0;
      end else if (push) begin
         wr_ptr_q <= wr_ptr_q + 1'b1;
         if (!full) cnt_q <= cnt_q + 1'b1;
      end else if (pop && !empty) begin
         wr_ptr_q <= wr_ptr_q - 1'b1;
         cnt_q    <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem_q[wr_ptr_q] <= push_val;
   end

   assign top_valid = !empty;
   assign top_val   = mem_q[wr_ptr_q - 1'b1];

endmodule

// File: rtl/ftp_next_pc_sel.sv
module ftp_next_pc_sel #(
   parameter int unsigned PC_W = 32
) (
   input  logic               fetch_pc_i [1],
   input  logic [PC_W-1:0]    fetch_pc,
   input  logic               is_ret,
   input  logic               stk_valid,
   input  logic [PC_W-1:0]    stk_val,
   input  logic               tbl_hit,
   input  logic [PC_W-1:0]    tbl_target,
   output logic               taken,
   output logic [PC_W-1:0]    next_pc,
   output ftp_pkg::pred_src_e src
);
   import ftp_pkg::*;

   logic [PC_W-1:0] seq_pc;
   logic            unused_dummy;

   assign unused_dummy = fetch_pc_i[0];
   assign seq_pc = fetch_pc + PC_W'(INSTR_BYTES);

   // Return hint owns the decision: stack or sequential, never the table
   always_comb begin
      src = SRC_SEQ;
      if (is_ret) begin
         if (stk_valid) src = SRC_STACK;
      end else if (tbl_hit) begin
         src = SRC_TABLE;
      end
   end

   always_comb begin
      unique case (src)
         SRC_STACK: next_pc = stk_val;
         SRC_TABLE: next_pc = tbl_target;
         default:   next_pc = seq_pc;
      endcase
   end

   assign taken = (src != SRC_SEQ);

endmodule

// File: rtl/fetch_target_pred.sv
module fetch_target_pred #(
   parameter int unsigned PC_W      = 32,
   parameter int unsigned IDX_W     = 4,
   parameter int unsigned RAS_DEPTH = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   input  logic            fetch_call,
   input  logic            fetch_ret,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken,
   input  logic [PC_W-1:0] upd_target,
   output logic            pred_taken,
   output logic [PC_W-1:0] pred_next_pc,
   output logic            pred_hit,
   output logic            pred_from_ras
);
   import ftp_pkg::*;

   logic            tbl_hit, stk_valid;
   logic [PC_W-1:0] tbl_target, stk_val, ret_addr;
   pred_src_e       src;
   logic            tie_lo [1];

   assign tie_lo[0] = 1'b0;
   assign ret_addr  = fetch_pc + PC_W'(INSTR_BYTES);

   ftp_target_table #(.PC_W(PC_W), .IDX_W(IDX_W)) u_table (
      .clk(clk), .rst_n(rst_n),
      .look_pc(fetch_pc), .look_hit(tbl_hit), .look_target(tbl_target),
      .upd_valid(upd_valid), .upd_pc(upd_pc),
      .upd_taken(upd_taken), .upd_target(upd_target)
   );

   ftp_return_stack #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_stack (
      .clk(clk), .rst_n(rst_n),
      .push(fetch_call), .push_val(ret_addr),
      .pop(fetch_ret),
      .top_valid(stk_valid), .top_val(stk_val)
   );

   ftp_next_pc_sel #(.PC_W(PC_W)) u_sel (
      .fetch_pc_i(tie_lo),
      .fetch_pc(fetch_pc), .is_ret(fetch_ret),
      .stk_valid(stk_valid), .stk_val(stk_val),
      .tbl_hit(tbl_hit), .tbl_target(tbl_target),
      .taken(pred_taken), .next_pc(pred_next_pc), .src(src)
   );

   assign pred_hit      = (src == SRC_TABLE);
   assign pred_from_ras = (src == SRC_STACK);

endmodule

// File: rtl/ftp_checker.sv
module ftp_checker #(
   parameter int unsigned PC_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] fetch_pc,
   input logic            fetch_call,
   input logic            fetch_ret,
   input logic            upd_valid,
   input logic [PC_W-1:0] upd_pc,
   input logic            upd_taken,
   input logic [PC_W-1:0] upd_target,
   input logic            pred_taken,
   input logic [PC_W-1:0] pred_next_pc,
   input logic            pred_hit,
   input logic            pred_from_ras
);

   AST_HINT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetch_call && fetch_ret));

   AST_NOT_TAKEN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_taken |-> (pred_next_pc == fetch_pc + PC_W'(4))); // R2

   AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pred_hit, pred_from_ras})); // R10

   AST_SRC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_hit || pred_from_ras) |-> pred_taken); // R10

   AST_RAS_NEEDS_RET: assert property (@(posedge clk) disable iff (!rst_n)
      pred_from_ras |-> fetch_ret); // R7

   AST_RET_NO_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_ret |-> !pred_hit); // R9

   AST_UPD_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken) |=>
         (!(fetch_pc == $past(upd_pc) && !fetch_ret) ||
          (pred_hit && pred_next_pc == $past(upd_target)))); // R4

   AST_CLEAR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_taken) |=>
         !(fetch_pc == $past(upd_pc) && pred_hit)); // R5

endmodule

bind fetch_target_pred ftp_checker #(.PC_W(PC_W)) u_chk (.*);

// File: tb/sim_fetch_target_pred.sv
`timescale 1ns/1ps
module sim_fetch_target_pred;
   localparam int unsigned PC_W = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [PC_W-1:0] fetch_pc = '0;
   logic            fetch_call = 1'b0, fetch_ret = 1'b0;
   logic            upd_valid = 1'b0, upd_taken = 1'b0;
   logic [PC_W-1:0] upd_pc = '0, upd_target = '0;
   logic            pred_taken, pred_hit, pred_from_ras;
   logic [PC_W-1:0] pred_next_pc;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   fetch_target_pred #(.PC_W(PC_W), .IDX_W(4), .RAS_DEPTH(4)) u0 (
      .clk(clk), .rst_n(rst_n),
      .fetch_pc(fetch_pc), .fetch_call(fetch_call), .fetch_ret(fetch_ret),
      .upd_valid(upd_valid), .upd_pc(upd_pc),
      .upd_taken(upd_taken), .upd_target(upd_target),
      .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
      .pred_hit(pred_hit), .pred_from_ras(pred_from_ras)
   );

   // Compare all outputs against expected values, one line per failure
   task automatic expect_pred(input string req, input logic t,
                              input logic [PC_W-1:0] npc,
                              input logic h, input logic r);
      checks++;
      if (pred_taken !== t || pred_next_pc !== npc ||
          pred_hit !== h || pred_from_ras !== r) begin
         errors++;
         $display("FAIL %s pc=%h: got taken=%b next=%h hit=%b ras=%b, exp taken=%b next=%h hit=%b ras=%b",
                  req, fetch_pc, pred_taken, pred_next_pc, pred_hit, pred_from_ras,
                  t, npc, h, r);
      end
   endtask

   // Present a lookup at the falling edge and sample 1 ns later
   task automatic look(input logic [PC_W-1:0] pc, input logic call, input logic ret);
      @(negedge clk);
      fetch_pc = pc; fetch_call = call; fetch_ret = ret;
      upd_valid = 1'b0;
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      fetch_call = 1'b0; fetch_ret = 1'b0; upd_valid = 1'b0;
   endtask

   task automatic update(input logic [PC_W-1:0] pc, input logic tk,
                         input logic [PC_W-1:0] tgt);
      @(negedge clk);
      fetch_call = 1'b0; fetch_ret = 1'b0;
      upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt;
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   task automatic t_reset();
      look(32'h0000_0040, 1'b0, 1'b0);
      expect_pred("R1", 1'b0, 32'h0000_0044, 1'b0, 1'b0);
      look(32'h0000_0100, 1'b0, 1'b0);
      expect_pred("R1", 1'b0, 32'h0000_0104, 1'b0, 1'b0);
      idle();
   endtask

   task automatic t_hit_alias();
      update(32'h0000_1000, 1'b1, 32'h0000_3000);
      look(32'h0000_1000, 1'b0, 1'b0);
      expect_pred("R3", 1'b1, 32'h0000_3000, 1'b1, 1'b0);
      look(32'h0000_2000, 1'b0, 1'b0);   // same slot, other tag
      expect_pred("R2", 1'b0, 32'h0000_2004, 1'b0, 1'b0);
      look(32'h0000_1004, 1'b0, 1'b0);   // neighbouring slot, still empty
      expect_pred("R2", 1'b0, 32'h0000_1008, 1'b0, 1'b0);
      update(32'h0000_1000, 1'b1, 32'h0000_3800);   // retarget
      look(32'h0000_1000, 1'b0, 1'b0);
      expect_pred("R4", 1'b1, 32'h0000_3800, 1'b1, 1'b0);
      idle();
   endtask

   task automatic t_clear();
      update(32'h0000_2000, 1'b0, 32'h0);   // tag differs: entry kept
      look(32'h0000_1000, 1'b0, 1'b0);
      expect_pred("R5", 1'b1, 32'h0000_3800, 1'b1, 1'b0);
      update(32'h0000_1000, 1'b0, 32'h0);   // tag matches: entry cleared
      look(32'h0000_1000, 1'b0, 1'b0);
      expect_pred("R5", 1'b0, 32'h0000_1004, 1'b0, 1'b0);
      idle();
   endtask

   task automatic t_same_cycle();
      @(negedge clk);
      fetch_pc = 32'h0000_0A08; fetch_call = 1'b0; fetch_ret = 1'b0;
      upd_valid = 1'b1; upd_pc = 32'h0000_0A08; upd_taken = 1'b1;
      upd_target = 32'h0000_7000;
      #1;
      expect_pred("R6", 1'b0, 32'h0000_0A0C, 1'b0, 1'b0);
      @(negedge clk);
      upd_valid = 1'b0;
      #1;
      expect_pred("R6", 1'b1, 32'h0000_7000, 1'b1, 1'b0);
      idle();
   endtask

   task automatic t_stack_basic();
      update(32'h0000_1040, 1'b1, 32'h0000_5000);
      look(32'h0000_0800, 1'b1, 1'b0);   // call: pushes 0x804
      look(32'h0000_1040, 1'b0, 1'b1);   // return at a table-hit PC
      expect_pred("R7", 1'b1, 32'h0000_0804, 1'b0, 1'b1);
      look(32'h0000_1040, 1'b0, 1'b0);   // popped; table still serves plain lookup
      expect_pred("R3", 1'b1, 32'h0000_5000, 1'b1, 1'b0);
      idle();
   endtask

   task automatic t_stack_wrap();
      for (int k = 1; k <= 5; k++) look(PC_W'(k * 32'h100), 1'b1, 1'b0);
      for (int k = 5; k >= 2; k--) begin
         look(32'h0000_0900, 1'b0, 1'b1);
         expect_pred("R8", 1'b1, PC_W'(k * 32'h100 + 4), 1'b0, 1'b1);
      end
      look(32'h0000_0900, 1'b0, 1'b1);   // oldest was overwritten: now empty
      expect_pred("R8", 1'b0, 32'h0000_0904, 1'b0, 1'b0);
      idle();
   endtask

   task automatic t_stack_empty();
      look(32'h0000_1040, 1'b0, 1'b1);   // table has this PC, stack empty
      expect_pred("R9", 1'b0, 32'h0000_1044, 1'b0, 1'b0);
      look(32'h0000_1040, 1'b0, 1'b1);
      expect_pred("R9", 1'b0, 32'h0000_1044, 1'b0, 1'b0);
      look(32'h0000_0C00, 1'b1, 1'b0);   // stack still works afterwards
      look(32'h0000_0D00, 1'b0, 1'b1);
      expect_pred("R10", 1'b1, 32'h0000_0C04, 1'b0, 1'b1);
      idle();
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_hit_alias();
      t_clear();
      t_same_cycle();
      t_stack_basic();
      t_stack_wrap();
      t_stack_empty();
      repeat (2) @(posedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule